// File: doc/BRIEF.md
# Registered Bus Transceiver

This block links an A-side bus and a B-side bus through two independent byte-wide lanes. Each lane can pass the value present on one bus straight through to the other. It can also hold one word per side in a register and drive that stored word later, even after the bus it came from has changed. Each lane has its own direction select, active-low output enable, two source selects and two capture strobes, so the two lanes can run in opposite directions or in different modes in the same cycle.

The pins are modelled without internal tristate. Each bus side is split into an input vector, an output vector and one drive flag per lane, and pad logic outside the block combines them. The capture strobes are sampled on the block clock, and a register loads on the clock edge that first sees its strobe high after it was low. A register always captures the value actually present on its bus. When the lane itself drives that bus, the register takes the driven value, so one transfer can be stored on both sides. Captures keep working while a lane drives neither bus.

Top module: `xcvr_bidir_top`

## Requirements
- R1: A synchronous active-high reset clears both registers of every lane to zero and clears the strobe history. A replay of stored data right after reset drives zero.
- R2: The A register of a lane loads the lane's A bus value on the first clock edge at which its A-capture strobe is seen high after being low. It keeps its contents while the strobe stays high or low.
- R3: The B register of a lane loads the lane's B bus value on the first clock edge at which its B-capture strobe is seen high after being low. It keeps its contents otherwise.
- R4: With the lane's output enable high (disabled), both drive flags are 0 and both output vectors of that lane are 0. Captures still take place.
- R5: With the output enable low, direction 1 sets the B drive flag and direction 0 sets the A drive flag. The two flags are never set together.
- R6: When the B side is driven, A-to-B select 0 drives the live A input byte and select 1 drives the stored A register. An undriven B output byte is 0.
- R7: When the A side is driven, B-to-A select 0 drives the live B input byte and select 1 drives the stored B register. An undriven A output byte is 0.
- R8: A register whose bus is driven by its own lane captures the driven output value rather than the input vector. A single live transfer can therefore be stored into both registers at once.
- R9: Lane i uses bus bits [8i+7:8i] and control bit i only. A lane's strobes and controls never change the other lane's registers or outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; strobes are sampled and registers load on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 16 | Value seen on the A bus pins, two bytes |
| b_in | input | 16 | Value seen on the B bus pins, two bytes |
| cap_ab | input | 2 | Per-lane A-capture strobe, a rising transition loads the A register |
| cap_ba | input | 2 | Per-lane B-capture strobe, a rising transition loads the B register |
| dir | input | 2 | Per-lane direction: 1 drives B, 0 drives A |
| oe_n | input | 2 | Per-lane output enable, active low |
| sel_ab | input | 2 | Per-lane source for the B side: 0 live, 1 stored |
| sel_ba | input | 2 | Per-lane source for the A side: 0 live, 1 stored |
| a_out | output | 16 | Value to drive onto the A bus |
| a_oe | output | 2 | Per-lane A drive flag |
| b_out | output | 16 | Value to drive onto the B bus |
| b_oe | output | 2 | Per-lane B drive flag |

## Verification
A capture and a replay can fall in the same cycle. A register may load on the edge at which its stored word is being driven out, and a capture of a driven bus takes the value the lane itself produces. The sweep changes strobes, selects, direction and data together on every step, with the two lanes given complementary controls. A reference model in the bench reads the outputs before each edge and then applies the captures. The value driven before the edge must be the old stored word, and the loaded value must be the word on the bus at that edge. Directed cases add a simultaneous capture into both registers from one live transfer.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int LANES_DEF  = 2;
    localparam int LANE_W_DEF = 8;

    typedef enum logic {
        SRC_LIVE   = 1'b0,
        SRC_STORED = 1'b1
    } src_sel_e;

    typedef enum logic {
        TOWARD_A = 1'b0,
        TOWARD_B = 1'b1
    } dir_e;

    typedef struct packed {
        logic     oe_n;
        dir_e     dir;
        src_sel_e src_b;
        src_sel_e src_a;
    } lane_ctrl_t;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } drive_t;

    function automatic drive_t decode_drive(lane_ctrl_t c);
        drive_t d;
        d.drive_b = !c.oe_n && (c.dir == TOWARD_B);
        d.drive_a = !c.oe_n && (c.dir == TOWARD_A);
        return d;
    endfunction

endpackage

// File: rtl/xcvr_rise.sv
module xcvr_rise #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] lvl_q;

    always_ff @(posedge clk) begin
        if (rst) lvl_q <= '0;
        else     lvl_q <= lvl;
    end

    assign rise = lvl & ~lvl_q & {W{!rst}};

    a_r2_rise_needs_low_history: assert property (@(posedge clk) disable iff (rst)
        (rise != '0) |-> ((rise & $past(lvl)) == '0 || $past(rst)));
endmodule

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)       q <= '0;
        else if (load) q <= d;
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (q == '0));
    a_r2_load_takes_bus: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));
    a_r3_hold_without_strobe: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));
endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = LANE_W_DEF
) (
    input  logic         clk,
    input  logic         rst,
    input  lane_ctrl_t   ctrl,
    input  logic         cap_ab,
    input  logic         cap_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [1:0]   rise;
    logic [W-1:0] reg_a, reg_b;
    logic [W-1:0] bus_a, bus_b;
    drive_t       drv;

    xcvr_rise #(.W(2)) u_rise (
        .clk  (clk),
        .rst  (rst),
        .lvl  ({cap_ba, cap_ab}),
        .rise (rise)
    );

    always_comb begin
        drv   = decode_drive(ctrl);
        b_out = '0;
        a_out = '0;
        if (drv.drive_b) b_out = (ctrl.src_b == SRC_STORED) ? reg_a : a_in;
        if (drv.drive_a) a_out = (ctrl.src_a == SRC_STORED) ? reg_b : b_in;
        bus_a = drv.drive_a ? a_out : a_in;
        bus_b = drv.drive_b ? b_out : b_in;
    end

    assign a_oe = drv.drive_a;
    assign b_oe = drv.drive_b;

    xcvr_store #(.W(W)) u_reg_a (
        .clk (clk), .rst (rst), .load (rise[0]), .d (bus_a), .q (reg_a)
    );

    xcvr_store #(.W(W)) u_reg_b (
        .clk (clk), .rst (rst), .load (rise[1]), .d (bus_b), .q (reg_b)
    );

    a_r4_isolated_quiet: assert property (@(posedge clk) disable iff (rst)
        ctrl.oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));
    a_r5_single_driver: assert property (@(posedge clk) disable iff (rst)
        !(a_oe && b_oe));
    a_r6_live_to_b: assert property (@(posedge clk) disable iff (rst)
        (b_oe && ctrl.src_b == SRC_LIVE) |-> (b_out == a_in));
    a_r7_stored_to_a: assert property (@(posedge clk) disable iff (rst)
        (a_oe && ctrl.src_a == SRC_STORED && !rise[1]) |=> (!a_oe || ctrl.src_a != SRC_STORED || a_out == $past(a_out)));
    a_r8_capture_driven_b: assert property (@(posedge clk) disable iff (rst)
        (rise[1] && b_oe) |=> (reg_b == $past(b_out)));
endmodule

// File: rtl/xcvr_bidir_top.sv
module xcvr_bidir_top
    import xcvr_pkg::*;
#(
    parameter int LANES  = LANES_DEF,
    parameter int LANE_W = LANE_W_DEF
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LANES*LANE_W-1:0]  a_in,
    input  logic [LANES*LANE_W-1:0]  b_in,
    input  logic [LANES-1:0]         cap_ab,
    input  logic [LANES-1:0]         cap_ba,
    input  logic [LANES-1:0]         dir,
    input  logic [LANES-1:0]         oe_n,
    input  logic [LANES-1:0]         sel_ab,
    input  logic [LANES-1:0]         sel_ba,
    output logic [LANES*LANE_W-1:0]  a_out,
    output logic [LANES-1:0]         a_oe,
    output logic [LANES*LANE_W-1:0]  b_out,
    output logic [LANES-1:0]         b_oe
);
    localparam int BUS_W = LANES * LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_ctrl_t c;
        always_comb begin
            c.oe_n  = oe_n[g];
            c.dir   = dir_e'(dir[g]);
            c.src_b = src_sel_e'(sel_ab[g]);
            c.src_a = src_sel_e'(sel_ba[g]);
        end

        xcvr_lane #(.W(LANE_W)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .ctrl   (c),
            .cap_ab (cap_ab[g]),
            .cap_ba (cap_ba[g]),
            .a_in   (a_in[g*LANE_W +: LANE_W]),
            .b_in   (b_in[g*LANE_W +: LANE_W]),
            .a_out  (a_out[g*LANE_W +: LANE_W]),
            .a_oe   (a_oe[g]),
            .b_out  (b_out[g*LANE_W +: LANE_W]),
            .b_oe   (b_oe[g])
        );
    end

    a_r9_lane_flags_pair: assert property (@(posedge clk) disable iff (rst)
        ((a_oe | b_oe) == ~oe_n) && (a_out[BUS_W-1:0] & {BUS_W{1'b1}}) == a_out);
endmodule

// File: tb/test_xcvr_bidir_top.sv
module test_xcvr_bidir_top;
    localparam int PERIOD = 10;
    localparam int L = 2;
    localparam int W = 8;

    logic clk = 1'b0;
    logic rst;
    logic [L*W-1:0] a_in, b_in, a_out, b_out;
    logic [L-1:0] cap_ab, cap_ba, dir, oe_n, sel_ab, sel_ba, a_oe, b_oe;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] ma [L];
    logic [W-1:0] mb [L];
    logic [L-1:0] pab, pba;

    always #(PERIOD/2) clk = ~clk;

    xcvr_bidir_top i_xcvr_bidir_top (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in),
        .cap_ab(cap_ab), .cap_ba(cap_ba), .dir(dir), .oe_n(oe_n),
        .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_b(int l);
        if (oe_n[l] || !dir[l]) return '0;
        return sel_ab[l] ? ma[l] : a_in[l*W +: W];
    endfunction

    function automatic logic [W-1:0] exp_a(int l);
        if (oe_n[l] || dir[l]) return '0;
        return sel_ba[l] ? mb[l] : b_in[l*W +: W];
    endfunction

    task automatic check_all();
        for (int l = 0; l < L; l++) begin
            chk("R5 a_oe", 32'(a_oe[l]), 32'(!oe_n[l] && !dir[l]));
            chk("R5 b_oe", 32'(b_oe[l]), 32'(!oe_n[l] && dir[l]));
            chk("R6 b_out", 32'(b_out[l*W +: W]), 32'(exp_b(l)));
            chk("R7 a_out", 32'(a_out[l*W +: W]), 32'(exp_a(l)));
        end
    endtask

    task automatic model_clock();
        for (int l = 0; l < L; l++) begin
            logic [W-1:0] ea, eb;
            ea = (!oe_n[l] && !dir[l]) ? exp_a(l) : a_in[l*W +: W];
            eb = (!oe_n[l] &&  dir[l]) ? exp_b(l) : b_in[l*W +: W];
            if (cap_ab[l] && !pab[l]) ma[l] = ea;
            if (cap_ba[l] && !pba[l]) mb[l] = eb;
        end
        pab = cap_ab;
        pba = cap_ba;
    endtask

    task automatic step();
        #1;
        check_all();
        model_clock();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(PERIOD * 200000);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0; cap_ab = '0; cap_ba = '0;
        dir = '0; oe_n = '1; sel_ab = '0; sel_ba = '0;
        for (int l = 0; l < L; l++) begin ma[l] = '0; mb[l] = '0; end
        pab = '0; pba = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: replay straight after reset gives zero
        a_in = 16'hFFFF; b_in = 16'hFFFF;
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        #1 chk("R1 b_out after reset", 32'(b_out), 32'h0);
        step();
        dir = 2'b00; sel_ba = 2'b11;
        #1 chk("R1 a_out after reset", 32'(a_out), 32'h0);
        step();

        // R4 + R2: isolated capture of A, strobe held high must not reload
        oe_n = 2'b11; sel_ab = 2'b00; sel_ba = 2'b00;
        a_in = 16'h995A; cap_ab = 2'b01;
        #1 chk("R4 isolated flags", 32'({a_oe, b_oe}), 32'h0);
        chk("R4 isolated outputs", 32'({a_out, b_out}), 32'h0);
        step();
        a_in = 16'h9911;
        step();
        oe_n = 2'b10; dir = 2'b01; sel_ab = 2'b01;
        #1 chk("R2 replay after held strobe", 32'(b_out[7:0]), 32'h5A);
        step();
        cap_ab = 2'b00;
        step();

        // R3: isolated capture of B, replayed on A
        oe_n = 2'b11; b_in = 16'h00C3; cap_ba = 2'b01;
        step();
        b_in = 16'h0044;
        oe_n = 2'b10; dir = 2'b00; sel_ba = 2'b01;
        #1 chk("R3 B register replay", 32'(a_out[7:0]), 32'hC3);
        step();
        cap_ba = 2'b00;
        step();

        // R8: one live A->B transfer stored into both registers
        oe_n = 2'b10; dir = 2'b01; sel_ab = 2'b00; sel_ba = 2'b00;
        a_in = 16'h0077; b_in = 16'h00EE;
        cap_ab = 2'b01; cap_ba = 2'b01;
        step();
        cap_ab = 2'b00; cap_ba = 2'b00; a_in = 16'h0000;
        dir = 2'b00; sel_ba = 2'b01;
        #1 chk("R8 B register holds driven value", 32'(a_out[7:0]), 32'h77);
        step();
        dir = 2'b01; sel_ab = 2'b01;
        #1 chk("R8 A register holds driven value", 32'(b_out[7:0]), 32'h77);
        step();

        // R9: lane 1 captures alone, lane 0 contents untouched
        oe_n = 2'b11; a_in = 16'h3CAA; cap_ab = 2'b10;
        step();
        cap_ab = 2'b00;
        oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
        #1 chk("R9 lane1 stored", 32'(b_out[15:8]), 32'h3C);
        chk("R9 lane0 unchanged", 32'(b_out[7:0]), 32'h77);
        step();

        // Sweep: complementary controls per lane, data and strobes varying
        for (int pass = 0; pass < 3; pass++) begin
            for (int k = 0; k < 64; k++) begin
                logic [3:0] c0;
                c0 = 4'(k);
                oe_n   = {~c0[3], c0[3]};
                dir    = {~c0[2], c0[2]};
                sel_ab = {~c0[1], c0[1]};
                sel_ba = {~c0[0], c0[0]};
                cap_ab = {k[5], k[4]};
                cap_ba = {k[4] ^ pass[0], k[5]};
                a_in   = 16'((k * 37 + pass * 101) * 257 + 13);
                b_in   = 16'((k * 91 + pass * 59) * 131 + 7);
                step();
            end
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule